// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the hardware side of taking an exception in a simple in-order core. Each cycle the pipeline may present one fault request. The request names the fault kind and says whether the access was a load or a store. It also carries the faulting PC, the virtual address, the address-space identifier, the virtual page number and a coprocessor number. In the cycle after a request is accepted, the block has done four things. It has written the exception code into the cause register. It has updated the bad-address, translation-high and context registers as the fault kind requires. It has raised the exception-level bit and saved the return PC. It has also sent a one-cycle redirect carrying the vector address to instruction fetch.

The vector is a base plus an offset. The base is the programmable exception base register when the bootstrap bit is clear. It is the fixed boot address `BOOT_BASE` (default 0xBFC00200) when that bit is set. The offset depends on the fault kind, on the exception-level bit and on the interrupt-vector bit of the cause register. A register write port loads any of the held registers, and every register is visible on an output.

Top module: `exc_entry`

## Requirements
- R1: After reset, the bootstrap bit is 1. The exception-level bit, the interrupt-vector bit, the code, the CE field, the base, EPC, the bad address, the translation-high fields, the context field and the redirect strobe are all 0.
- R2: The input `flt_kind_i` encodes the fault kinds as follows: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 instruction bus error, 6 data bus error, 7 syscall, 8 breakpoint, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 coprocessor-2 error, 14 media extension, 15 watch, 16 machine check, 17 thread, 18 cache error. On a fault, `cause_code_o` becomes, in the same order, 0, 1, (2/3), (2/3), (4/5), 6, 7, 8, 9, 10, 11, 12, 13, 18, 22, 23, 24, 25, 30.
- R3: For TLB refill and TLB invalid faults, the code is 2 for a load and 3 for a store (`flt_store_i`=1). For an address error, it is 4 for a load and 5 for a store. A TLB-modified fault reports 1 whatever `flt_store_i` is.
- R4: The vector base is `ebase_o` when the bootstrap bit is 0 and `BOOT_BASE` when it is 1.
- R5: An interrupt uses offset 0x200 when the interrupt-vector bit is 1 and offset 0x180 when it is 0.
- R6: A TLB refill uses offset 0x000 when the exception-level bit was 0 and offset 0x180 when it was already 1. Every other kind except an interrupt uses offset 0x180.
- R7: Address-error and TLB faults (kinds 1 to 4) load `flt_vaddr_i` into the bad-address register. Other kinds leave it unchanged.
- R8: On TLB faults (kinds 1 to 3), the translation-high ASID takes `flt_asid_i`. Its VPN2 field and the context field take `flt_vpn_i` shifted right by 2, and its VPN2X field takes `flt_vpn_i[1:0]`. Other kinds leave all four fields unchanged.
- R9: A coprocessor-unusable fault loads `flt_cp_i` into the CE field. Other kinds leave CE unchanged.
- R10: A fault loads `flt_pc_i` into EPC only when the exception-level bit was 0, and it always leaves the exception-level bit at 1. The bootstrap and interrupt-vector bits are unchanged.
- R11: One cycle after a fault request, `redir_valid_o` is 1 for exactly one cycle and `redir_addr_o` holds base plus offset (modulo 2^VA_W). Without a request, `redir_valid_o` is 0.
- R12: With `wr_en_i`=1, `wr_sel_i` selects the register to load from `wr_data_i`:
  - 0 status: bit0 exception level, bit1 bootstrap.
  - 1 cause: bits 4:0 code, bit 8 interrupt vector, bits 13:12 CE.
  - 2 exception base.
  - 3 EPC.
  - 4 bad address.
  - 5 translation high: bits 7:0 ASID, bits 9:8 VPN2X, bits 28:10 VPN2.
  - 6 context: bits 18:0.

  A write in the same cycle as a fault request is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flt_valid_i | input | 1 | Fault request this cycle |
| flt_kind_i | input | 5 | Fault kind (R2 encoding) |
| flt_store_i | input | 1 | Faulting access was a store |
| flt_pc_i | input | VA_W | PC of the faulting instruction |
| flt_vaddr_i | input | VA_W | Faulting virtual address |
| flt_asid_i | input | ASID_W | Address-space identifier |
| flt_vpn_i | input | VPN_W | Virtual page number |
| flt_cp_i | input | CP_W | Coprocessor number |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | VA_W | Write data |
| redir_valid_o | output | 1 | Fetch redirect strobe |
| redir_addr_o | output | VA_W | Vector address |
| status_bev_o | output | 1 | Bootstrap bit |
| status_exl_o | output | 1 | Exception-level bit |
| cause_code_o | output | 5 | Exception code |
| cause_iv_o | output | 1 | Interrupt-vector bit |
| cause_ce_o | output | CP_W | Coprocessor number of last unusable fault |
| ebase_o | output | VA_W | Exception base |
| epc_o | output | VA_W | Exception return PC |
| badva_o | output | VA_W | Bad virtual address |
| hi_asid_o | output | ASID_W | Translation-high ASID |
| hi_vpn2_o | output | VPN_W-2 | Translation-high VPN2 |
| hi_vpn2x_o | output | 2 | Translation-high VPN2X |
| ctx_vpn2_o | output | VPN_W-2 | Context bad VPN2 |

## Verification
The assertions assume that `flt_kind_i` carries one of the 19 defined kinds whenever a request is valid. They also assume that a write issued together with a fault is expected to vanish, and that the stored registers change only through the write port or a fault. The stimulus never drives a kind above 18 with a valid request. Before each request, it rewrites every register through the write port to a known value, so that the unchanged-field expectations are well defined. The sweep covers every kind against both access types and every combination of the bootstrap, exception-level and interrupt-vector bits.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int CODE_W = 5;
    localparam int KIND_W = 5;
    localparam int SEL_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        FK_INT      = 5'd0,
        FK_TLB_MOD  = 5'd1,
        FK_TLB_REF  = 5'd2,
        FK_TLB_INV  = 5'd3,
        FK_ADDR     = 5'd4,
        FK_IBUS     = 5'd5,
        FK_DBUS     = 5'd6,
        FK_SYS      = 5'd7,
        FK_BRK      = 5'd8,
        FK_RSVD     = 5'd9,
        FK_CPU      = 5'd10,
        FK_OVF      = 5'd11,
        FK_TRAP     = 5'd12,
        FK_CP2      = 5'd13,
        FK_MEDIA    = 5'd14,
        FK_WATCH    = 5'd15,
        FK_MCHK     = 5'd16,
        FK_THREAD   = 5'd17,
        FK_CACHE    = 5'd18
    } fault_kind_e;

    localparam logic [SEL_W-1:0] WS_STATUS = 3'd0;
    localparam logic [SEL_W-1:0] WS_CAUSE  = 3'd1;
    localparam logic [SEL_W-1:0] WS_EBASE  = 3'd2;
    localparam logic [SEL_W-1:0] WS_EPC    = 3'd3;
    localparam logic [SEL_W-1:0] WS_BADVA  = 3'd4;
    localparam logic [SEL_W-1:0] WS_HI     = 3'd5;
    localparam logic [SEL_W-1:0] WS_CTX    = 3'd6;

    localparam int CAUSE_IV_BIT = 8;
    localparam int CAUSE_CE_LSB = 12;
endpackage

// File: rtl/exc_code_sel.sv
module exc_code_sel
    import exc_entry_pkg::*;
(
    input  fault_kind_e         kind_i,
    input  logic                store_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                tlb_o,
    output logic                addr_o
);
    always_comb begin
        tlb_o  = 1'b0;
        addr_o = 1'b0;
        unique case (kind_i)
            FK_INT:     code_o = 5'd0;
            FK_TLB_MOD: begin code_o = 5'd1; tlb_o = 1'b1; end
            FK_TLB_REF,
            FK_TLB_INV: begin code_o = store_i ? 5'd3 : 5'd2; tlb_o = 1'b1; end
            FK_ADDR:    begin code_o = store_i ? 5'd5 : 5'd4; addr_o = 1'b1; end
            FK_IBUS:    code_o = 5'd6;
            FK_DBUS:    code_o = 5'd7;
            FK_SYS:     code_o = 5'd8;
            FK_BRK:     code_o = 5'd9;
            FK_RSVD:    code_o = 5'd10;
            FK_CPU:     code_o = 5'd11;
            FK_OVF:     code_o = 5'd12;
            FK_TRAP:    code_o = 5'd13;
            FK_CP2:     code_o = 5'd18;
            FK_MEDIA:   code_o = 5'd22;
            FK_WATCH:   code_o = 5'd23;
            FK_MCHK:    code_o = 5'd24;
            FK_THREAD:  code_o = 5'd25;
            FK_CACHE:   code_o = 5'd30;
            default:    code_o = 5'd0;
        endcase
    end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
    import exc_entry_pkg::*;
#(
    parameter int               VA_W      = 32,
    parameter logic [VA_W-1:0]  BOOT_BASE = 32'hBFC0_0200
) (
    input  fault_kind_e         kind_i,
    input  logic                bev_i,
    input  logic                exl_i,
    input  logic                iv_i,
    input  logic [VA_W-1:0]     ebase_i,
    output logic [VA_W-1:0]     vec_o
);
    localparam logic [VA_W-1:0] OFF_GEN = VA_W'(12'h180);
    localparam logic [VA_W-1:0] OFF_IRQ = VA_W'(12'h200);
    localparam logic [VA_W-1:0] OFF_REF = '0;

    logic [VA_W-1:0] base;
    logic [VA_W-1:0] offset;

    always_comb begin
        base = bev_i ? BOOT_BASE : ebase_i;
        case (kind_i)
            FK_INT:     offset = iv_i ? OFF_IRQ : OFF_GEN;
            FK_TLB_REF: offset = exl_i ? OFF_GEN : OFF_REF;
            default:    offset = OFF_GEN;
        endcase
        vec_o = base + offset;
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int               VA_W      = 32,
    parameter int               ASID_W    = 8,
    parameter int               VPN_W     = 21,
    parameter int               CP_W      = 2,
    parameter logic [VA_W-1:0]  BOOT_BASE = 32'hBFC0_0200
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                flt_valid_i,
    input  logic [KIND_W-1:0]   flt_kind_i,
    input  logic                flt_store_i,
    input  logic [VA_W-1:0]     flt_pc_i,
    input  logic [VA_W-1:0]     flt_vaddr_i,
    input  logic [ASID_W-1:0]   flt_asid_i,
    input  logic [VPN_W-1:0]    flt_vpn_i,
    input  logic [CP_W-1:0]     flt_cp_i,
    input  logic                wr_en_i,
    input  logic [SEL_W-1:0]    wr_sel_i,
    input  logic [VA_W-1:0]     wr_data_i,
    output logic                redir_valid_o,
    output logic [VA_W-1:0]     redir_addr_o,
    output logic                status_bev_o,
    output logic                status_exl_o,
    output logic [CODE_W-1:0]   cause_code_o,
    output logic                cause_iv_o,
    output logic [CP_W-1:0]     cause_ce_o,
    output logic [VA_W-1:0]     ebase_o,
    output logic [VA_W-1:0]     epc_o,
    output logic [VA_W-1:0]     badva_o,
    output logic [ASID_W-1:0]   hi_asid_o,
    output logic [VPN_W-3:0]    hi_vpn2_o,
    output logic [1:0]          hi_vpn2x_o,
    output logic [VPN_W-3:0]    ctx_vpn2_o
);
    localparam int VPN2_W    = VPN_W - 2;
    localparam int HI_X_LSB  = ASID_W;
    localparam int HI_V_LSB  = ASID_W + 2;

    typedef struct packed {
        logic               bev;
        logic               exl;
        logic [CODE_W-1:0]  code;
        logic               iv;
        logic [CP_W-1:0]    ce;
        logic [VA_W-1:0]    ebase;
        logic [VA_W-1:0]    epc;
        logic [VA_W-1:0]    badva;
        logic [ASID_W-1:0]  asid;
        logic [VPN2_W-1:0]  vpn2;
        logic [1:0]         vpn2x;
        logic [VPN2_W-1:0]  ctx;
        logic               rv;
        logic [VA_W-1:0]    raddr;
    } state_t;

    state_t state_d, state_q;

    fault_kind_e        kind;
    logic [CODE_W-1:0]  code;
    logic               is_tlb;
    logic               is_addr;
    logic [VA_W-1:0]    vec;

    assign kind = fault_kind_e'(flt_kind_i);

    exc_code_sel u_code (
        .kind_i  (kind),
        .store_i (flt_store_i),
        .code_o  (code),
        .tlb_o   (is_tlb),
        .addr_o  (is_addr)
    );

    exc_vec_gen #(.VA_W(VA_W), .BOOT_BASE(BOOT_BASE)) u_vec (
        .kind_i  (kind),
        .bev_i   (state_q.bev),
        .exl_i   (state_q.exl),
        .iv_i    (state_q.iv),
        .ebase_i (state_q.ebase),
        .vec_o   (vec)
    );

    always_comb begin
        state_d    = state_q;
        state_d.rv = 1'b0;
        if (flt_valid_i) begin
            state_d.code = code;
            if (kind == FK_CPU) state_d.ce = flt_cp_i;
            if (is_tlb || is_addr) state_d.badva = flt_vaddr_i;
            if (is_tlb) begin
                state_d.asid  = flt_asid_i;
                state_d.vpn2  = flt_vpn_i[VPN_W-1:2];
                state_d.vpn2x = flt_vpn_i[1:0];
                state_d.ctx   = flt_vpn_i[VPN_W-1:2];
            end
            if (!state_q.exl) state_d.epc = flt_pc_i;
            state_d.exl   = 1'b1;
            state_d.rv    = 1'b1;
            state_d.raddr = vec;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                WS_STATUS: begin
                    state_d.exl = wr_data_i[0];
                    state_d.bev = wr_data_i[1];
                end
                WS_CAUSE: begin
                    state_d.code = wr_data_i[CODE_W-1:0];
                    state_d.iv   = wr_data_i[CAUSE_IV_BIT];
                    state_d.ce   = wr_data_i[CAUSE_CE_LSB +: CP_W];
                end
                WS_EBASE: state_d.ebase = wr_data_i;
                WS_EPC:   state_d.epc   = wr_data_i;
                WS_BADVA: state_d.badva = wr_data_i;
                WS_HI: begin
                    state_d.asid  = wr_data_i[ASID_W-1:0];
                    state_d.vpn2x = wr_data_i[HI_X_LSB +: 2];
                    state_d.vpn2  = wr_data_i[HI_V_LSB +: VPN2_W];
                end
                WS_CTX:   state_d.ctx = wr_data_i[VPN2_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= '0;
            state_q.bev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign redir_valid_o = state_q.rv;
    assign redir_addr_o  = state_q.raddr;
    assign status_bev_o  = state_q.bev;
    assign status_exl_o  = state_q.exl;
    assign cause_code_o  = state_q.code;
    assign cause_iv_o    = state_q.iv;
    assign cause_ce_o    = state_q.ce;
    assign ebase_o       = state_q.ebase;
    assign epc_o         = state_q.epc;
    assign badva_o       = state_q.badva;
    assign hi_asid_o     = state_q.asid;
    assign hi_vpn2_o     = state_q.vpn2;
    assign hi_vpn2x_o    = state_q.vpn2x;
    assign ctx_vpn2_o    = state_q.ctx;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int CP_W = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                flt_valid_i,
    input  logic [KIND_W-1:0]   flt_kind_i,
    input  logic [CP_W-1:0]     flt_cp_i,
    input  logic                wr_en_i,
    input  logic [SEL_W-1:0]    wr_sel_i,
    input  logic                redir_valid_o,
    input  logic                status_exl_o,
    input  logic [CODE_W-1:0]   cause_code_o,
    input  logic [CP_W-1:0]     cause_ce_o,
    input  logic [VA_W-1:0]     ebase_o,
    input  logic [VA_W-1:0]     epc_o
);
    assert_kind_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_valid_i |-> (flt_kind_i <= 5'd18));

    assert_tlbmod_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_valid_i && flt_kind_i == 5'd1) |=> (cause_code_o == 5'd1));

    assert_ce_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_valid_i && flt_kind_i == 5'd10) |=> (cause_ce_o == $past(flt_cp_i)));

    assert_exl_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_valid_i |=> status_exl_o);

    assert_epc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_valid_i && status_exl_o) |=> $stable(epc_o));

    assert_redir_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_valid_i |=> redir_valid_o);

    assert_redir_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flt_valid_i |=> !redir_valid_o);

    assert_write_dropped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_valid_i && wr_en_i && wr_sel_i == WS_EBASE) |=> $stable(ebase_o));
endmodule

bind exc_entry exc_entry_chk #(.VA_W(VA_W), .CP_W(CP_W)) u_chk (.*);

// File: tb/exc_entry_test.sv
module exc_entry_test;
    localparam int VA_W = 32;
    localparam int ASID_W = 8;
    localparam int VPN_W = 21;
    localparam int CP_W = 2;
    localparam logic [31:0] BOOT = 32'hBFC0_0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flt_valid = 1'b0;
    logic [4:0] flt_kind = '0;
    logic flt_store = 1'b0;
    logic [31:0] flt_pc = '0, flt_vaddr = '0;
    logic [7:0] flt_asid = '0;
    logic [20:0] flt_vpn = '0;
    logic [1:0] flt_cp = '0;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic redir_valid;
    logic [31:0] redir_addr, ebase, epc, badva;
    logic bev, exl, iv;
    logic [4:0] code;
    logic [1:0] ce;
    logic [7:0] asid;
    logic [18:0] vpn2, ctx;
    logic [1:0] vpn2x;

    int checks = 0;
    int errors = 0;

    exc_entry uut (
        .clk_i(clk), .rst_ni(rst_n),
        .flt_valid_i(flt_valid), .flt_kind_i(flt_kind), .flt_store_i(flt_store),
        .flt_pc_i(flt_pc), .flt_vaddr_i(flt_vaddr), .flt_asid_i(flt_asid),
        .flt_vpn_i(flt_vpn), .flt_cp_i(flt_cp),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .redir_valid_o(redir_valid), .redir_addr_o(redir_addr),
        .status_bev_o(bev), .status_exl_o(exl), .cause_code_o(code),
        .cause_iv_o(iv), .cause_ce_o(ce), .ebase_o(ebase), .epc_o(epc),
        .badva_o(badva), .hi_asid_o(asid), .hi_vpn2_o(vpn2),
        .hi_vpn2x_o(vpn2x), .ctx_vpn2_o(ctx)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [4:0] exp_code(input int k, input logic st);
        case (k)
            0: return 5'd0;   1: return 5'd1;
            2, 3: return st ? 5'd3 : 5'd2;
            4: return st ? 5'd5 : 5'd4;
            13: return 5'd18; 14: return 5'd22; 15: return 5'd23;
            16: return 5'd24; 17: return 5'd25; 18: return 5'd30;
            default: return 5'(k + 1);
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 bev", 64'(bev), 1);
        chk("R1 exl", 64'(exl), 0);
        chk("R1 code/iv/ce", 64'({code, iv, ce}), 0);
        chk("R1 regs", 64'(ebase | epc | badva), 0);
        chk("R1 hi/ctx", 64'({asid, vpn2, vpn2x, ctx}), 0);
        chk("R1 redir", 64'(redir_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 19; k++) begin
            for (int m = 0; m < 16; m++) begin
                logic st, b, x, v;
                logic [31:0] eb, pre_epc, pre_bad, base, off, pc, va;
                logic [7:0] a;
                logic [20:0] vp;
                logic [1:0] cp;
                logic tlb;
                st = m[0]; b = m[1]; x = m[2]; v = m[3];
                eb = 32'h8000_0000 | (32'(k) << 12);
                pre_epc = 32'h1111_0000 + 32'(idx);
                pre_bad = 32'h2222_0000 + 32'(idx);
                wr(3'd2, eb);
                wr(3'd0, {30'd0, b, x});
                wr(3'd1, (32'd1 << 12) | (32'(v) << 8) | 32'd31);
                wr(3'd3, pre_epc);
                wr(3'd4, pre_bad);
                wr(3'd5, {3'd0, 19'h5A5A5, 2'd2, 8'hC3});
                wr(3'd6, 32'h0003_3333);
                // R12 write port readback
                chk("R12 ebase", 64'(ebase), 64'(eb));
                chk("R12 status", 64'({bev, exl}), 64'({b, x}));
                chk("R12 cause", 64'({code, iv, ce}), 64'({5'd31, v, 2'd1}));
                chk("R12 hi", 64'({asid, vpn2x, vpn2}), 64'({8'hC3, 2'd2, 19'h5A5A5}));
                chk("R12 ctx", 64'(ctx), 64'h3_3333);

                pc = 32'h0040_0000 + 32'(idx * 4);
                va = 32'h7000_0000 ^ (32'(idx) << 4);
                a = 8'(idx * 7 + 1);
                vp = 21'(idx * 37 + 5);
                cp = 2'(idx);
                flt_valid = 1'b1; flt_kind = 5'(k); flt_store = st;
                flt_pc = pc; flt_vaddr = va; flt_asid = a; flt_vpn = vp; flt_cp = cp;
                @(negedge clk);
                flt_valid = 1'b0;

                tlb = (k >= 1 && k <= 3);
                base = b ? BOOT : eb;
                off = (k == 0) ? (v ? 32'h200 : 32'h180)
                    : (k == 2) ? (x ? 32'h180 : 32'h0) : 32'h180;
                chk("R2 R3 code", 64'(code), 64'(exp_code(k, st)));
                chk("R4 R5 R6 R11 vector", 64'(redir_addr), 64'(base + off));
                chk("R11 strobe", 64'(redir_valid), 1);
                chk("R7 badva", 64'(badva), 64'((tlb || k == 4) ? va : pre_bad));
                chk("R8 hi", 64'({asid, vpn2, vpn2x}),
                    tlb ? 64'({a, vp[20:2], vp[1:0]}) : 64'({8'hC3, 19'h5A5A5, 2'd2}));
                chk("R8 ctx", 64'(ctx), tlb ? 64'(vp[20:2]) : 64'h3_3333);
                chk("R9 ce", 64'(ce), 64'((k == 10) ? cp : 2'd1));
                chk("R10 epc", 64'(epc), 64'(x ? pre_epc : pc));
                chk("R10 bits", 64'({exl, bev, iv}), 64'({1'b1, b, v}));
                @(negedge clk);
                chk("R11 one cycle", 64'(redir_valid), 0);
                idx++;
            end
        end

        // R12 write dropped when a fault arrives in the same cycle
        wr(3'd0, 32'd0);
        wr(3'd2, 32'h9000_0000);
        flt_valid = 1'b1; flt_kind = 5'd7; flt_store = 1'b0; flt_pc = 32'h1234;
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'hDEAD_0000;
        @(negedge clk);
        flt_valid = 1'b0; wr_en = 1'b0;
        chk("R12 ebase kept", 64'(ebase), 64'h9000_0000);
        chk("R12 R11 vector", 64'(redir_addr), 64'h9000_0180);
        flt_valid = 1'b1; flt_pc = 32'h5678;
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'hBEEF_0000;
        @(negedge clk);
        flt_valid = 1'b0; wr_en = 1'b0;
        chk("R12 R10 epc kept", 64'(epc), 64'h1234);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule